// File: doc/BRIEF.md
# External Memory Access Router

This block sits between a small processor's external-data access port and two targets: a 4 KB on-chip data RAM and an off-chip memory bus. For each access request it forms a 16-bit effective address, decides which target receives the access, and then either issues a single-cycle on-chip RAM access or runs an off-chip bus cycle. An off-chip cycle has an address-latch-enable (ALE) high phase, an ALE low phase and a one-cycle read or write strobe.

A small configuration register selects the routing mode, the ALE phase width and the bus style. The bus style is either a shared address/data bus or separate address and data pins. Short accesses carry only an 8-bit address. For these the block supplies the upper address byte from one of two inputs: the address-high port latch value or the page register value. While an off-chip cycle is in progress the block holds `acc_busy` high, and the processor must not issue another request until it falls.

Top module: `xmem_router`

## Requirements
- R1: The configuration register resets to 0x0F. Field layout: bits [1:0] are the routing mode, bits [3:2] are the ALE width field, bit 4 selects separate buses (1) or the shared multiplexed bus (0). Bits [7:5] always read 0 and ignore writes. A write takes effect on the edge after `cfg_we`.
- R2: In routing mode 0 (on-chip only), every access goes on-chip at RAM address = effective address modulo 4096, and no off-chip cycle starts.
- R3: In routing mode 3 (off-chip only), every access starts an off-chip cycle, whatever its address, and `ram_en` never rises.
- R4: In routing modes 1 and 2, an effective address below 0x1000 goes on-chip and an address of 0x1000 or above goes off-chip.
- R5: A short access (`acc_short`=1) uses `acc_addr[7:0]` as its low byte. In modes 0, 1 and 3 its upper byte is `latch_hi`.
- R6: In mode 2 a short access takes its upper byte from `page_hi`. An upper byte of 0x00 to 0x0F still routes the access on-chip.
- R7: With ALE width field N, `ext_ale` stays high for N+1 cycles starting the cycle after acceptance. It then stays low for N+1 cycles before the strobe. Width and bus style are captured when the access is accepted.
- R8: After the ALE low phase, exactly one strobe cycle follows: `ext_rd_n` is low for a read and `ext_wr_n` is low for a write. `acc_busy` is high for all 2(N+1)+1 cycles of the off-chip cycle. Requests made while busy are ignored.
- R9: In shared-bus mode, `ext_ad_out` carries the low address byte with `ext_ad_oe` high during ALE high, and carries the write data during a write strobe. In separate-bus mode it carries only the write data during a write strobe. `ext_ad_out` is 0 whenever `ext_ad_oe` is low.
- R10: An on-chip access pulses `ram_en` for one cycle on the cycle after acceptance, with `ram_we`, `ram_addr` and `ram_wdata` valid. `acc_busy` stays low during it.
- R11: `ext_addr` holds the full 16-bit address of the latest off-chip access from its acceptance onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration register write enable |
| cfg_wdata | input | 8 | Configuration write value |
| cfg_rdata | output | 8 | Configuration register contents |
| latch_hi | input | 8 | Address-high port latch value |
| page_hi | input | 8 | Page register value |
| acc_req | input | 1 | Access request, sampled when not busy |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_short | input | 1 | 1 = 8-bit address access |
| acc_addr | input | 16 | Access address |
| acc_wdata | input | 8 | Write data |
| acc_busy | output | 1 | Off-chip cycle in progress |
| ram_en | output | 1 | On-chip RAM access strobe |
| ram_we | output | 1 | On-chip RAM write enable |
| ram_addr | output | 12 | On-chip RAM address |
| ram_wdata | output | 8 | On-chip RAM write data |
| ext_ale | output | 1 | Off-chip address latch enable |
| ext_rd_n | output | 1 | Off-chip read strobe, active low |
| ext_wr_n | output | 1 | Off-chip write strobe, active low |
| ext_addr | output | 16 | Off-chip address |
| ext_ad_out | output | 8 | Address/data bus drive value |
| ext_ad_oe | output | 1 | Address/data bus drive enable |

## Verification
The hardest case to reach is a short access in a split mode whose upper byte, taken from the latch or page input, decodes back below the 4 KB boundary. The stimulus sets `latch_hi` and `page_hi` to values on both sides of 0x10 in both split modes. It issues short accesses with each setting and checks which target responds. A second awkward case is a request raised while an off-chip cycle runs. The bench drives one mid-cycle and checks that the address and strobe outputs of the running cycle are unchanged and that no new cycle follows.

// File: rtl/xmr_pkg.sv
// Shared types and sizes for the external memory access router.
// Assumes a 16-bit effective address and a 4 KB on-chip RAM.
package xmr_pkg;
    localparam int ADDR_W    = 16;
    localparam int DATA_W    = 8;
    localparam int ONCHIP_AW = 12;
    localparam int ALE_FW    = 2;

    typedef enum logic [1:0] {
        RT_ONCHIP     = 2'd0,
        RT_SPLIT_LATCH = 2'd1,
        RT_SPLIT_PAGE  = 2'd2,
        RT_OFFCHIP    = 2'd3
    } route_mode_e;

    typedef struct packed {
        logic              sep_bus;
        logic [ALE_FW-1:0] ale_w;
        route_mode_e       mode;
    } xmr_cfg_t;

    typedef enum logic [1:0] {
        SQ_IDLE   = 2'd0,
        SQ_ALE_HI = 2'd1,
        SQ_ALE_LO = 2'd2,
        SQ_STROBE = 2'd3
    } seq_state_e;
endpackage

// File: rtl/xmr_cfg_reg.sv
// Configuration register: routing mode, ALE width field and bus style.
// Assumes byte-wide writes; unused upper bits read as zero.
module xmr_cfg_reg
    import xmr_pkg::*;
#(
    parameter int REG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [REG_W-1:0] wdata,
    output xmr_cfg_t         cfg,
    output logic [REG_W-1:0] rdata
);
    localparam int CFG_W = $bits(xmr_cfg_t);

    // Hold the configuration; reset selects off-chip only with the widest ALE.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '{sep_bus: 1'b0, ale_w: '1, mode: RT_OFFCHIP};
        end else if (we) begin
            cfg <= xmr_cfg_t'(wdata[CFG_W-1:0]);
        end
    end

    // Zero-extend the stored fields for read-back.
    always_comb begin
        rdata = '0;
        rdata[CFG_W-1:0] = cfg;
    end
endmodule

// File: rtl/xmr_route_decode.sv
// Forms the full effective address and chooses the target for an access.
// Assumes the on-chip region starts at address zero.
module xmr_route_decode
    import xmr_pkg::*;
#(
    parameter int AW  = ADDR_W,
    parameter int OAW = ONCHIP_AW
) (
    input  route_mode_e   mode,
    input  logic          short_acc,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    latch_hi,
    input  logic [7:0]    page_hi,
    output logic [AW-1:0] full_addr,
    output logic          to_onchip
);
    logic [7:0] hi_sel;
    logic       below_bound;

    // Pick the upper byte source for short accesses.
    always_comb begin
        hi_sel = (mode == RT_SPLIT_PAGE) ? page_hi : latch_hi;
        if (short_acc) full_addr = {hi_sel[AW-9:0], addr[7:0]};
        else           full_addr = addr;
    end

    // Decide target from mode and the fixed on-chip boundary.
    always_comb begin
        below_bound = (full_addr[AW-1:OAW] == '0);
        unique case (mode)
            RT_ONCHIP:  to_onchip = 1'b1;
            RT_OFFCHIP: to_onchip = 1'b0;
            default:    to_onchip = below_bound;
        endcase
    end
endmodule

// File: rtl/xmr_bus_seq.sv
// Off-chip cycle sequencer: ALE high, ALE low, then one strobe cycle.
// Assumes start is only pulsed while idle; captures width and bus style at start.
module xmr_bus_seq
    import xmr_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    parameter int FW = ALE_FW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic [FW-1:0] ale_w,
    input  logic          sep_bus,
    output logic          busy,
    output logic          ale,
    output logic          rd_n,
    output logic          wr_n,
    output logic [AW-1:0] ext_addr,
    output logic [DW-1:0] ad_out,
    output logic          ad_oe
);
    seq_state_e    state;
    logic [FW-1:0] cnt;
    logic [FW-1:0] width_m1;
    logic          cyc_wr;
    logic          cyc_sep;
    logic [DW-1:0] cyc_data;

    // Advance through the phases, reloading the phase counter at each change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= SQ_IDLE;
            cnt      <= '0;
            width_m1 <= '0;
            cyc_wr   <= 1'b0;
            cyc_sep  <= 1'b0;
            cyc_data <= '0;
            ext_addr <= '0;
        end else begin
            unique case (state)
                SQ_IDLE: if (start) begin
                    state    <= SQ_ALE_HI;
                    cnt      <= ale_w;
                    width_m1 <= ale_w;
                    cyc_wr   <= wr;
                    cyc_sep  <= sep_bus;
                    cyc_data <= wdata;
                    ext_addr <= addr;
                end
                SQ_ALE_HI: if (cnt == '0) begin
                    state <= SQ_ALE_LO;
                    cnt   <= width_m1;
                end else begin
                    cnt <= cnt - 1'b1;
                end
                SQ_ALE_LO: if (cnt == '0) state <= SQ_STROBE;
                           else           cnt <= cnt - 1'b1;
                SQ_STROBE: state <= SQ_IDLE;
            endcase
        end
    end

    // Decode pin levels from the current phase.
    always_comb begin
        busy   = (state != SQ_IDLE);
        ale    = (state == SQ_ALE_HI);
        rd_n   = !((state == SQ_STROBE) && !cyc_wr);
        wr_n   = !((state == SQ_STROBE) && cyc_wr);
        ad_oe  = 1'b0;
        ad_out = '0;
        if (state == SQ_ALE_HI && !cyc_sep) begin
            ad_oe  = 1'b1;
            ad_out = ext_addr[DW-1:0];
        end else if (state == SQ_STROBE && cyc_wr) begin
            ad_oe  = 1'b1;
            ad_out = cyc_data;
        end
    end
endmodule

// File: rtl/xmem_router.sv
// External memory access router: routes each access to on-chip RAM or
// runs an off-chip bus cycle. Assumes requests arrive only while not busy;
// others are dropped.
module xmem_router
    import xmr_pkg::*;
#(
    parameter int AW  = ADDR_W,
    parameter int DW  = DATA_W,
    parameter int OAW = ONCHIP_AW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_we,
    input  logic [7:0]     cfg_wdata,
    output logic [7:0]     cfg_rdata,
    input  logic [7:0]     latch_hi,
    input  logic [7:0]     page_hi,
    input  logic           acc_req,
    input  logic           acc_wr,
    input  logic           acc_short,
    input  logic [AW-1:0]  acc_addr,
    input  logic [DW-1:0]  acc_wdata,
    output logic           acc_busy,
    output logic           ram_en,
    output logic           ram_we,
    output logic [OAW-1:0] ram_addr,
    output logic [DW-1:0]  ram_wdata,
    output logic           ext_ale,
    output logic           ext_rd_n,
    output logic           ext_wr_n,
    output logic [AW-1:0]  ext_addr,
    output logic [DW-1:0]  ext_ad_out,
    output logic           ext_ad_oe
);
    xmr_cfg_t      cfg;
    logic [AW-1:0] full_addr;
    logic          to_onchip;
    logic          accept;
    logic          start_ext;

    xmr_cfg_reg #(.REG_W(8)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
        .cfg(cfg), .rdata(cfg_rdata)
    );

    xmr_route_decode #(.AW(AW), .OAW(OAW)) u_dec (
        .mode(cfg.mode), .short_acc(acc_short), .addr(acc_addr),
        .latch_hi(latch_hi), .page_hi(page_hi),
        .full_addr(full_addr), .to_onchip(to_onchip)
    );

    // Accept a request only while no off-chip cycle runs.
    always_comb begin
        accept    = acc_req && !acc_busy;
        start_ext = accept && !to_onchip;
    end

    // Register the single-cycle on-chip RAM access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ram_en    <= 1'b0;
            ram_we    <= 1'b0;
            ram_addr  <= '0;
            ram_wdata <= '0;
        end else begin
            ram_en <= accept && to_onchip;
            ram_we <= accept && to_onchip && acc_wr;
            if (accept && to_onchip) begin
                ram_addr  <= full_addr[OAW-1:0];
                ram_wdata <= acc_wdata;
            end
        end
    end

    xmr_bus_seq #(.AW(AW), .DW(DW), .FW(ALE_FW)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start_ext), .wr(acc_wr),
        .addr(full_addr), .wdata(acc_wdata), .ale_w(cfg.ale_w),
        .sep_bus(cfg.sep_bus), .busy(acc_busy), .ale(ext_ale),
        .rd_n(ext_rd_n), .wr_n(ext_wr_n), .ext_addr(ext_addr),
        .ad_out(ext_ad_out), .ad_oe(ext_ad_oe)
    );
endmodule

// File: rtl/xmem_router_chk.sv
// Protocol checker for the external memory access router, bound to the top.
module xmem_router_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] cfg_rdata,
    input logic       acc_busy,
    input logic       ram_en,
    input logic       ext_ale,
    input logic       ext_rd_n,
    input logic       ext_wr_n,
    input logic [7:0] ext_ad_out,
    input logic       ext_ad_oe
);
    // R1
    cfg_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[7:5] == 3'b000);
    // R3
    no_ram_offchip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_en |-> $past(cfg_rdata[1:0]) != 2'b11);
    // R10
    onchip_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_en |-> !acc_busy);
    // R8
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ext_rd_n && !ext_wr_n));
    // R8
    rd_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_rd_n |=> ext_rd_n);
    // R8
    wr_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_wr_n |=> ext_wr_n);
    // R8
    busy_end_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(acc_busy) |-> $past(!ext_rd_n || !ext_wr_n));
    // R7
    ale_in_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_ale |-> acc_busy);
    // R9
    ad_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_ad_oe |-> ext_ad_out == 8'h00);
endmodule

bind xmem_router xmem_router_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_rdata(cfg_rdata), .acc_busy(acc_busy),
    .ram_en(ram_en), .ext_ale(ext_ale), .ext_rd_n(ext_rd_n),
    .ext_wr_n(ext_wr_n), .ext_ad_out(ext_ad_out), .ext_ad_oe(ext_ad_oe)
);

// File: tb/xmem_router_bench.sv
module xmem_router_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_rdata;
    logic [7:0]  latch_hi = '0;
    logic [7:0]  page_hi = '0;
    logic        acc_req = 1'b0;
    logic        acc_wr = 1'b0;
    logic        acc_short = 1'b0;
    logic [15:0] acc_addr = '0;
    logic [7:0]  acc_wdata = '0;
    logic        acc_busy, ram_en, ram_we;
    logic [11:0] ram_addr;
    logic [7:0]  ram_wdata;
    logic        ext_ale, ext_rd_n, ext_wr_n, ext_ad_oe;
    logic [15:0] ext_addr;
    logic [7:0]  ext_ad_out;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit cmp_on = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xmem_router u_xmem_router (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .latch_hi(latch_hi), .page_hi(page_hi),
        .acc_req(acc_req), .acc_wr(acc_wr), .acc_short(acc_short),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_busy(acc_busy),
        .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr),
        .ram_wdata(ram_wdata), .ext_ale(ext_ale), .ext_rd_n(ext_rd_n),
        .ext_wr_n(ext_wr_n), .ext_addr(ext_addr), .ext_ad_out(ext_ad_out),
        .ext_ad_oe(ext_ad_oe)
    );

    // Behavioural reference model state
    int m_cfg, m_phase, m_cnt, m_w, m_sep, m_wr, m_addr, m_wd;
    int m_ram_en, m_ram_we, m_ram_addr, m_ram_wd;
    int ram_hits = 0, ext_starts = 0;

    always @(posedge clk) begin
        int full, hi, mode, on;
        if (!rst_n) begin
            m_cfg = 'h0F; m_phase = 0; m_cnt = 0; m_w = 0; m_sep = 0; m_wr = 0;
            m_addr = 0; m_wd = 0; m_ram_en = 0; m_ram_we = 0;
            m_ram_addr = 0; m_ram_wd = 0;
        end else begin
            mode = m_cfg % 4;
            m_ram_en = 0; m_ram_we = 0;
            if (m_phase == 0) begin
                if (acc_req) begin
                    hi = (mode == 2) ? int'(page_hi) : int'(latch_hi);
                    full = acc_short ? hi * 256 + int'(acc_addr[7:0]) : int'(acc_addr);
                    on = (mode == 0) || (mode != 3 && full < 4096);
                    if (on) begin
                        m_ram_en = 1; m_ram_we = int'(acc_wr);
                        m_ram_addr = full % 4096; m_ram_wd = int'(acc_wdata);
                        ram_hits++;
                    end else begin
                        m_phase = 1; m_cnt = 0; m_w = (m_cfg / 4) % 4 + 1;
                        m_sep = (m_cfg / 16) % 2; m_wr = int'(acc_wr);
                        m_addr = full; m_wd = int'(acc_wdata);
                        ext_starts++;
                    end
                end
            end else if (m_phase == 3) begin
                m_phase = 0;
            end else begin
                m_cnt++;
                if (m_cnt == m_w) begin m_phase++; m_cnt = 0; end
            end
            if (cfg_we) m_cfg = int'(cfg_wdata) % 32;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
        end
    endtask

    // Compare every output with the model at each falling edge.
    always @(negedge clk) begin
        int e_oe, e_ad;
        if (cmp_on) begin
            e_oe = 0; e_ad = 0;
            if (m_phase == 1 && m_sep == 0) begin e_oe = 1; e_ad = m_addr % 256; end
            else if (m_phase == 3 && m_wr == 1) begin e_oe = 1; e_ad = m_wd; end
            chk("R1", "cfg_rdata", int'(cfg_rdata), m_cfg);
            chk("R8", "acc_busy", int'(acc_busy), int'(m_phase != 0));
            chk("R7", "ext_ale", int'(ext_ale), int'(m_phase == 1));
            chk("R8", "ext_rd_n", int'(ext_rd_n), int'(!(m_phase == 3 && m_wr == 0)));
            chk("R8", "ext_wr_n", int'(ext_wr_n), int'(!(m_phase == 3 && m_wr == 1)));
            chk("R11", "ext_addr", int'(ext_addr), m_addr);
            chk("R9", "ext_ad_oe", int'(ext_ad_oe), e_oe);
            chk("R9", "ext_ad_out", int'(ext_ad_out), e_ad);
            chk("R10", "ram_en", int'(ram_en), m_ram_en);
            chk("R10", "ram_we", int'(ram_we), m_ram_we);
            chk("R2", "ram_addr", int'(ram_addr), m_ram_addr);
            chk("R10", "ram_wdata", int'(ram_wdata), m_ram_wd);
        end
    end

    task automatic set_cfg(input logic [7:0] v);
        @(posedge clk); #1;
        cfg_we = 1'b1; cfg_wdata = v;
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    // One access; waits until any off-chip cycle completes.
    task automatic access(input logic [15:0] a, input logic sh, input logic w, input logic [7:0] d);
        @(posedge clk); #1;
        acc_req = 1'b1; acc_addr = a; acc_short = sh; acc_wr = w; acc_wdata = d;
        @(posedge clk); #1;
        acc_req = 1'b0;
        while (acc_busy) begin @(posedge clk); #1; end
    endtask

    // Count ALE-high cycles of one off-chip access.
    task automatic ale_width(input int expw);
        int hi_c = 0;
        @(posedge clk); #1;
        acc_req = 1'b1; acc_addr = 16'h8001; acc_short = 1'b0; acc_wr = 1'b0;
        @(posedge clk); #1;
        acc_req = 1'b0;
        while (acc_busy) begin
            if (ext_ale) hi_c++;
            @(posedge clk); #1;
        end
        chk("R7", "ale high cycles", hi_c, expw);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        cmp_on = 1'b1;
        @(negedge clk);
        chk("R1", "reset cfg value", int'(cfg_rdata), 'h0F);
        // R3: off-chip-only mode, low address still goes off-chip
        access(16'h0123, 1'b0, 1'b0, 8'h00);
        access(16'h0044, 1'b0, 1'b1, 8'hA5);
        chk("R3", "no ram access in mode 3", ram_hits, 0);
        // R1: upper bits ignore writes
        set_cfg(8'hFF);
        chk("R1", "upper bits read zero", int'(cfg_rdata), 'h1F);
        // R2: on-chip only, modulo aliasing
        set_cfg(8'h00);
        access(16'h5678, 1'b0, 1'b1, 8'h3C);
        chk("R2", "alias address", int'(ram_addr), 'h678);
        access(16'hFFFF, 1'b0, 1'b0, 8'h00);
        // R4/R5: split with latch, width 1, shared bus
        set_cfg(8'h01);
        access(16'h0FFF, 1'b0, 1'b1, 8'h11);
        access(16'h1000, 1'b0, 1'b1, 8'h22);
        chk("R4", "boundary goes off-chip", int'(ext_addr), 'h1000);
        latch_hi = 8'h20; page_hi = 8'h05;
        access(16'h0077, 1'b1, 1'b0, 8'h00);
        chk("R5", "latch upper byte", int'(ext_addr), 'h2077);
        latch_hi = 8'h0F;
        access(16'h00EE, 1'b1, 1'b1, 8'h5A);
        chk("R5", "latch below boundary on-chip", int'(ram_addr), 'hFEE);
        // R6: split with page, width 2
        set_cfg(8'h06);
        page_hi = 8'h35; latch_hi = 8'h02;
        access(16'h0099, 1'b1, 1'b1, 8'h66);
        chk("R6", "page upper byte", int'(ext_addr), 'h3599);
        page_hi = 8'h05; latch_hi = 8'h70;
        access(16'h0010, 1'b1, 1'b0, 8'h00);
        chk("R6", "page below boundary on-chip", int'(ram_addr), 'h510);
        // R9: separate bus, mode 2, width 3
        set_cfg(8'h1A);
        access(16'hC0DE, 1'b0, 1'b1, 8'h99);
        access(16'hBEEF, 1'b0, 1'b0, 8'h00);
        // R7: each width
        for (int n = 0; n < 4; n++) begin
            set_cfg(8'h03 | 8'(n << 2));
            ale_width(n + 1);
        end
        // R8: request during busy is ignored
        set_cfg(8'h07);
        @(posedge clk); #1;
        acc_req = 1'b1; acc_addr = 16'h4444; acc_short = 1'b0; acc_wr = 1'b1; acc_wdata = 8'h12;
        @(posedge clk); #1;
        acc_addr = 16'h9999; acc_wr = 1'b0;
        @(posedge clk); #1;
        acc_req = 1'b0;
        while (acc_busy) begin @(posedge clk); #1; end
        chk("R8", "address kept while busy", int'(ext_addr), 'h4444);
        repeat (4) @(posedge clk);
        #1 chk("R8", "no extra cycle", int'(acc_busy), 0);
        chk("R11", "ext addr held", int'(ext_addr), 'h4444);
        // R7: width captured at start, changed mid-cycle
        @(posedge clk); #1;
        acc_req = 1'b1; acc_addr = 16'h7000;
        @(posedge clk); #1;
        acc_req = 1'b0; cfg_we = 1'b1; cfg_wdata = 8'h03;
        @(posedge clk); #1;
        cfg_we = 1'b0;
        while (acc_busy) begin @(posedge clk); #1; end
        repeat (3) @(posedge clk);
        #1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule